// File: doc/BRIEF.md
# CAN Fault Confinement Error Counters

This block holds the transmit and receive error counters of a CAN controller and derives the node's fault confinement state from them. The state can be error-active, error-passive or bus-off. The protocol engine drives single-cycle event pulses into the block: a transmit error, a receive error, a successful transmit, a successful receive, and a sampled bus bit with its valid strobe. The block returns both counters, a 2-bit state code and a bus-off interrupt pulse. All counting runs in the protocol clock domain.

Once the node is in bus-off, the transmit counter is reused for recovery. It is chained behind an internal run counter, which wraps on every eleventh consecutive recessive bit. Each wrap adds one to the transmit counter. When 128 such runs have been seen, the node returns to error-active and both counters are cleared.

Software can preset the counters, but only while the host asserts freeze. A host write is first captured in an auxiliary register in the host clock domain. A toggle request then crosses into the protocol domain, and the counters take the new value there. An acknowledge toggle crosses back. A busy flag stays high until that acknowledge arrives, so software can poll it to see when the write has landed.

Top module: `can_fault_counters`

## Requirements
- R1: After reset both counters read 0, the state code is 00 (error-active), the interrupt is low and the host busy flag is low.
- R2: Outside bus-off, a transmit error adds 8 to the transmit counter. A successful transmit subtracts 1 when the counter is nonzero. When both arrive in the same cycle, the error wins.
- R3: Outside bus-off, a receive error adds 1 to the receive counter and saturates at 255. A successful receive subtracts 1 when the counter is nonzero and leaves 0 unchanged. When both arrive in the same cycle, the error wins.
- R4: Outside bus-off, the state code is 01 (error-passive) whenever either counter is 128 or more.
- R5: The state returns from 01 to 00 only once both counters are 127 or less.
- R6: A host write while freeze is high loads bits [15:8] into the transmit counter and bits [7:0] into the receive counter, after the handshake. The busy flag is high from the write until the acknowledge returns. The counters hold the new value by the time busy falls. A load during bus-off keeps the state at bus-off.
- R7: A host write while freeze is low is ignored: busy stays low and both counters keep their values.
- R8: A transmit error that would take the transmit counter above 255 sets the state code to 10 (bus-off) and clears the transmit counter. In that same cycle, the interrupt output pulses high for exactly one cycle.
- R9: In bus-off, transmit error, receive error, transmit success and receive success events change neither counter.
- R10: In bus-off, each run of 11 consecutive recessive bits (bit valid high with bus bit 1) adds 1 to the transmit counter. A dominant bit (bus bit 0) restarts the run.
- R11: When the transmit counter reaches 128 in bus-off, the state code becomes 00 and both counters are cleared. Normal counting then resumes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| canClk | input | 1 | Protocol clock |
| canRstN | input | 1 | Protocol-domain reset, active low |
| hostClk | input | 1 | Host clock |
| hostRstN | input | 1 | Host-domain reset, active low |
| freezeMode | input | 1 | Host-domain level; enables counter writes |
| hostWrEn | input | 1 | Host write strobe |
| hostWrData | input | 16 | Write data: transmit value in [15:8], receive value in [7:0] |
| hostBusy | output | 1 | High while a host write is in flight |
| txErrEvt | input | 1 | Transmit error pulse |
| rxErrEvt | input | 1 | Receive error pulse |
| txOkEvt | input | 1 | Successful transmit pulse |
| rxOkEvt | input | 1 | Successful receive pulse |
| bitValid | input | 1 | Sampled bus bit is valid this cycle |
| busBit | input | 1 | Sampled bus level, 1 = recessive |
| txCount | output | 8 | Transmit error counter |
| rxCount | output | 8 | Receive error counter |
| faultState | output | 2 | 00 active, 01 passive, 1x bus-off |
| busOffIrq | output | 1 | One-cycle pulse on bus-off entry |

## Verification
Every protocol event updates the counters, the state code and the interrupt at the first protocol clock edge after the pulse is driven. The bench drives each pulse just after a falling edge and pushes the expected result into a queue. The monitor pops and compares that result shortly after the next rising edge. A host write takes several cycles in both domains, so the bench checks busy right after the host edge that takes the write. It then polls busy until it falls, and only after that compares the loaded counters.

// File: rtl/fc_pkg.sv
package fc_pkg;

  typedef enum logic [1:0] {
    FC_ACTIVE  = 2'b00,
    FC_PASSIVE = 2'b01,
    FC_BUSOFF  = 2'b10
  } faultState_e;

  // Strobes from control to the counter datapath
  typedef struct packed {
    logic load;     // take host value into both counters
    logic txUp;     // transmit error step
    logic txDown;   // transmit success
    logic txStep;   // bus-off recovery increment
    logic txClear;
    logic rxUp;
    logic rxDown;
    logic rxClear;
  } cntStrobe_t;

endpackage

// File: rtl/fc_cdc_write.sv
module fc_cdc_write #(
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              hostClk,
  input  logic              hostRstN,
  input  logic              freezeMode,
  input  logic              hostWrEn,
  input  logic [DATA_W-1:0] hostWrData,
  output logic              hostBusy,
  input  logic              canClk,
  input  logic              canRstN,
  output logic              loadPulse,
  output logic [DATA_W-1:0] loadData
);

  logic                   reqTgl;
  logic [DATA_W-1:0]      auxReg;
  logic [SYNC_STAGES-1:0] ackSync;
  logic [SYNC_STAGES-1:0] reqSync;
  logic                   reqSeen;

  assign hostBusy = reqTgl ^ ackSync[SYNC_STAGES-1];

  // Host side: capture into the auxiliary register and flip the request
  always_ff @(posedge hostClk or negedge hostRstN) begin
    if (!hostRstN) begin
      reqTgl  <= 1'b0;
      auxReg  <= '0;
      ackSync <= '0;
    end else begin
      ackSync <= {ackSync[SYNC_STAGES-2:0], reqSeen};
      if (hostWrEn && freezeMode && !hostBusy) begin
        auxReg <= hostWrData;
        reqTgl <= ~reqTgl;
      end
    end
  end

  // Protocol side: detect the toggle, echo it back as the acknowledge
  always_ff @(posedge canClk or negedge canRstN) begin
    if (!canRstN) begin
      reqSync <= '0;
      reqSeen <= 1'b0;
    end else begin
      reqSync <= {reqSync[SYNC_STAGES-2:0], reqTgl};
      reqSeen <= reqSync[SYNC_STAGES-1];
    end
  end

  assign loadPulse = reqSync[SYNC_STAGES-1] ^ reqSeen;
  // auxReg is held stable for the whole time busy is high
  assign loadData  = auxReg;

endmodule

// File: rtl/fc_datapath.sv
module fc_datapath
  import fc_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int TX_ERR_STEP = 8
) (
  input  logic               canClk,
  input  logic               canRstN,
  input  cntStrobe_t         strobe,
  input  logic [2*CNT_W-1:0] loadData,
  output logic [CNT_W-1:0]   txCount,
  output logic [CNT_W-1:0]   rxCount,
  output logic [CNT_W-1:0]   txNext,
  output logic [CNT_W-1:0]   rxNext
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);
  localparam logic [CNT_W-1:0] TX_STEP = CNT_W'(TX_ERR_STEP);

  always_comb begin
    txNext = txCount;
    rxNext = rxCount;
    if (strobe.load) begin
      txNext = loadData[2*CNT_W-1:CNT_W];
      rxNext = loadData[CNT_W-1:0];
    end else begin
      if (strobe.txClear)                       txNext = '0;
      else if (strobe.txUp)                     txNext = txCount + TX_STEP;
      else if (strobe.txStep)                   txNext = txCount + ONE;
      else if (strobe.txDown && txCount != '0)  txNext = txCount - ONE;

      if (strobe.rxClear) begin
        rxNext = '0;
      end else if (strobe.rxUp) begin
        if (rxCount != CNT_MAX) rxNext = rxCount + ONE;
      end else if (strobe.rxDown && rxCount != '0) begin
        rxNext = rxCount - ONE;
      end
    end
  end

  always_ff @(posedge canClk or negedge canRstN) begin
    if (!canRstN) begin
      txCount <= '0;
      rxCount <= '0;
    end else begin
      txCount <= txNext;
      rxCount <= rxNext;
    end
  end

endmodule

// File: rtl/fc_ctrl.sv
module fc_ctrl
  import fc_pkg::*;
#(
  parameter int CNT_W         = 8,
  parameter int TX_ERR_STEP   = 8,
  parameter int PASSIVE_LIMIT = 128,
  parameter int RUN_LEN       = 11,
  parameter int RECOVER_COUNT = 128
) (
  input  logic             canClk,
  input  logic             canRstN,
  input  logic             txErrEvt,
  input  logic             rxErrEvt,
  input  logic             txOkEvt,
  input  logic             rxOkEvt,
  input  logic             bitValid,
  input  logic             busBit,
  input  logic             loadPulse,
  input  logic [CNT_W-1:0] txCount,
  input  logic [CNT_W-1:0] txNext,
  input  logic [CNT_W-1:0] rxNext,
  output cntStrobe_t       strobe,
  output logic [1:0]       faultState,
  output logic             busOffIrq
);

  localparam int               RUN_W       = $clog2(RUN_LEN);
  localparam logic [RUN_W-1:0] RUN_LAST    = RUN_W'(RUN_LEN - 1);
  localparam logic [RUN_W-1:0] RUN_ONE     = RUN_W'(1);
  localparam logic [CNT_W-1:0] PASSIVE_LVL = CNT_W'(PASSIVE_LIMIT);
  localparam logic [CNT_W-1:0] RECOVER_PRE = CNT_W'(RECOVER_COUNT - 1);
  localparam logic [CNT_W:0]   STEP_EXT    = (CNT_W+1)'(TX_ERR_STEP);

  logic             busOff;
  logic             passive;
  logic             irqReg;
  logic [RUN_W-1:0] runCnt;
  logic [CNT_W:0]   txSum;
  logic             overflow;
  logic             runWrap;
  logic             recover;
  logic             live;

  assign live     = !busOff && !loadPulse;
  assign txSum    = {1'b0, txCount} + STEP_EXT;
  assign overflow = live && txErrEvt && txSum[CNT_W];
  assign runWrap  = busOff && !loadPulse && bitValid && busBit && (runCnt == RUN_LAST);
  assign recover  = runWrap && (txCount == RECOVER_PRE);

  always_comb begin
    strobe         = '0;
    strobe.load    = loadPulse;
    strobe.txClear = overflow || recover;
    strobe.txUp    = live && txErrEvt;
    strobe.txDown  = live && txOkEvt;
    strobe.txStep  = runWrap;
    strobe.rxClear = recover;
    strobe.rxUp    = live && rxErrEvt;
    strobe.rxDown  = live && rxOkEvt;
  end

  always_ff @(posedge canClk or negedge canRstN) begin
    if (!canRstN) begin
      busOff  <= 1'b0;
      passive <= 1'b0;
      irqReg  <= 1'b0;
      runCnt  <= '0;
    end else begin
      irqReg  <= overflow;
      passive <= (txNext >= PASSIVE_LVL) || (rxNext >= PASSIVE_LVL);
      if (overflow) begin
        busOff <= 1'b1;
        runCnt <= '0;
      end else if (recover) begin
        busOff <= 1'b0;
        runCnt <= '0;
      end else if (busOff && bitValid && !loadPulse) begin
        if (!busBit)      runCnt <= '0;
        else if (runWrap) runCnt <= '0;
        else              runCnt <= runCnt + RUN_ONE;
      end
    end
  end

  always_comb begin
    if (busOff)       faultState = FC_BUSOFF;
    else if (passive) faultState = FC_PASSIVE;
    else              faultState = FC_ACTIVE;
  end

  assign busOffIrq = irqReg;

endmodule

// File: rtl/can_fault_counters.sv
module can_fault_counters
  import fc_pkg::*;
#(
  parameter int CNT_W         = 8,
  parameter int TX_ERR_STEP   = 8,
  parameter int PASSIVE_LIMIT = 128,
  parameter int RUN_LEN       = 11,
  parameter int RECOVER_COUNT = 128,
  parameter int SYNC_STAGES   = 2
) (
  input  logic               canClk,
  input  logic               canRstN,
  input  logic               hostClk,
  input  logic               hostRstN,
  input  logic               freezeMode,
  input  logic               hostWrEn,
  input  logic [2*CNT_W-1:0] hostWrData,
  output logic               hostBusy,
  input  logic               txErrEvt,
  input  logic               rxErrEvt,
  input  logic               txOkEvt,
  input  logic               rxOkEvt,
  input  logic               bitValid,
  input  logic               busBit,
  output logic [CNT_W-1:0]   txCount,
  output logic [CNT_W-1:0]   rxCount,
  output logic [1:0]         faultState,
  output logic               busOffIrq
);

  logic               loadPulse;
  logic [2*CNT_W-1:0] loadData;
  cntStrobe_t         strobe;
  logic [CNT_W-1:0]   txNext;
  logic [CNT_W-1:0]   rxNext;

  fc_cdc_write #(.DATA_W(2*CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_cdc (
    .hostClk(hostClk), .hostRstN(hostRstN), .freezeMode(freezeMode),
    .hostWrEn(hostWrEn), .hostWrData(hostWrData), .hostBusy(hostBusy),
    .canClk(canClk), .canRstN(canRstN),
    .loadPulse(loadPulse), .loadData(loadData)
  );

  fc_ctrl #(
    .CNT_W(CNT_W), .TX_ERR_STEP(TX_ERR_STEP), .PASSIVE_LIMIT(PASSIVE_LIMIT),
    .RUN_LEN(RUN_LEN), .RECOVER_COUNT(RECOVER_COUNT)
  ) u_ctrl (
    .canClk(canClk), .canRstN(canRstN),
    .txErrEvt(txErrEvt), .rxErrEvt(rxErrEvt), .txOkEvt(txOkEvt), .rxOkEvt(rxOkEvt),
    .bitValid(bitValid), .busBit(busBit), .loadPulse(loadPulse),
    .txCount(txCount), .txNext(txNext), .rxNext(rxNext),
    .strobe(strobe), .faultState(faultState), .busOffIrq(busOffIrq)
  );

  fc_datapath #(.CNT_W(CNT_W), .TX_ERR_STEP(TX_ERR_STEP)) u_dp (
    .canClk(canClk), .canRstN(canRstN), .strobe(strobe), .loadData(loadData),
    .txCount(txCount), .rxCount(rxCount), .txNext(txNext), .rxNext(rxNext)
  );

endmodule

// File: rtl/fc_checker.sv
module fc_checker #(
  parameter int CNT_W         = 8,
  parameter int PASSIVE_LIMIT = 128
) (
  input logic             canClk,
  input logic             canRstN,
  input logic             hostClk,
  input logic             hostRstN,
  input logic             freezeMode,
  input logic             hostBusy,
  input logic             txErrEvt,
  input logic             rxErrEvt,
  input logic             bitValid,
  input logic             loadPulse,
  input logic [CNT_W-1:0] txCount,
  input logic [CNT_W-1:0] rxCount,
  input logic [1:0]       faultState,
  input logic             busOffIrq
);

  localparam logic [CNT_W-1:0] LVL = CNT_W'(PASSIVE_LIMIT);
  localparam logic [CNT_W-1:0] TOP = '1;

  assert_irq_single_R8: assert property (@(posedge canClk) disable iff (!canRstN)
    busOffIrq |=> !busOffIrq);

  assert_busoff_entry_R8: assert property (@(posedge canClk) disable iff (!canRstN)
    $rose(faultState[1]) |-> (txCount == '0 && busOffIrq));

  assert_busoff_ignore_R9: assert property (@(posedge canClk) disable iff (!canRstN)
    (faultState[1] && !loadPulse && !bitValid) |=> ($stable(txCount) && $stable(rxCount)));

  assert_passive_level_R4: assert property (@(posedge canClk) disable iff (!canRstN)
    (!faultState[1] && (txCount >= LVL || rxCount >= LVL)) |-> faultState == 2'b01);

  assert_active_level_R5: assert property (@(posedge canClk) disable iff (!canRstN)
    (!faultState[1] && txCount < LVL && rxCount < LVL) |-> faultState == 2'b00);

  assert_rx_saturate_R3: assert property (@(posedge canClk) disable iff (!canRstN)
    (!faultState[1] && !loadPulse && rxErrEvt && rxCount == TOP) |=> rxCount == TOP);

  assert_tx_step_R2: assert property (@(posedge canClk) disable iff (!canRstN)
    (!faultState[1] && !loadPulse && txErrEvt && txCount < 8'd248) |=> txCount == $past(txCount) + 8'd8);

  assert_no_write_unfrozen_R7: assert property (@(posedge hostClk) disable iff (!hostRstN)
    (!hostBusy && !freezeMode) |=> !hostBusy);

endmodule

bind can_fault_counters fc_checker #(.CNT_W(CNT_W), .PASSIVE_LIMIT(PASSIVE_LIMIT)) u_chk (
  .canClk(canClk), .canRstN(canRstN), .hostClk(hostClk), .hostRstN(hostRstN),
  .freezeMode(freezeMode), .hostBusy(hostBusy),
  .txErrEvt(txErrEvt), .rxErrEvt(rxErrEvt), .bitValid(bitValid), .loadPulse(loadPulse),
  .txCount(txCount), .rxCount(rxCount), .faultState(faultState), .busOffIrq(busOffIrq)
);

// File: tb/tb_can_fault_counters.sv
module tb_can_fault_counters;

  logic        canClk = 1'b0;
  logic        hostClk = 1'b0;
  logic        canRstN = 1'b0;
  logic        hostRstN = 1'b0;
  logic        freezeMode = 1'b0;
  logic        hostWrEn = 1'b0;
  logic [15:0] hostWrData = '0;
  logic        hostBusy;
  logic        txErrEvt = 1'b0, rxErrEvt = 1'b0, txOkEvt = 1'b0, rxOkEvt = 1'b0;
  logic        bitValid = 1'b0, busBit = 1'b0;
  logic [7:0]  txCount, rxCount;
  logic [1:0]  faultState;
  logic        busOffIrq;

  can_fault_counters dut (
    .canClk(canClk), .canRstN(canRstN), .hostClk(hostClk), .hostRstN(hostRstN),
    .freezeMode(freezeMode), .hostWrEn(hostWrEn), .hostWrData(hostWrData), .hostBusy(hostBusy),
    .txErrEvt(txErrEvt), .rxErrEvt(rxErrEvt), .txOkEvt(txOkEvt), .rxOkEvt(rxOkEvt),
    .bitValid(bitValid), .busBit(busBit),
    .txCount(txCount), .rxCount(rxCount), .faultState(faultState), .busOffIrq(busOffIrq)
  );

  always #10 canClk = ~canClk;   // 50 MHz protocol clock
  always #7  hostClk = ~hostClk; // unrelated host clock

  int nChecks = 0;
  int nFail   = 0;
  bit finished = 1'b0;

  // reference model
  int mTx = 0, mRx = 0, mRun = 0, mIrq = 0;
  bit mBusOff = 1'b0;

  typedef struct packed { logic [7:0] tx; logic [7:0] rx; logic [1:0] st; logic irq; } exp_t;
  exp_t  expQ[$];
  string tagQ[$];

  function automatic logic [1:0] modelState();
    if (mBusOff) return 2'b10;
    if (mTx >= 128 || mRx >= 128) return 2'b01;
    return 2'b00;
  endfunction

  task automatic pushExp(input string tag);
    exp_t e;
    e.tx = 8'(mTx); e.rx = 8'(mRx); e.st = modelState(); e.irq = 1'(mIrq);
    expQ.push_back(e);
    tagQ.push_back(tag);
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // monitor: compares one expected item just after each rising edge
  always @(posedge canClk) begin
    #2;
    if (expQ.size() > 0) begin
      exp_t e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      nChecks++;
      if (txCount !== e.tx || rxCount !== e.rx || faultState !== e.st || busOffIrq !== e.irq) begin
        nFail++;
        $display("FAIL %s: actual tx=%0d rx=%0d st=%0d irq=%0d expected tx=%0d rx=%0d st=%0d irq=%0d",
                 t, txCount, rxCount, faultState, busOffIrq, e.tx, e.rx, e.st, e.irq);
      end
    end
  end

  // driver: one protocol-event cycle, called just after a falling edge
  task automatic applyEvt(input logic te, input logic re, input logic to, input logic ro,
                          input logic bv, input logic bb, input string tag);
    txErrEvt = te; rxErrEvt = re; txOkEvt = to; rxOkEvt = ro; bitValid = bv; busBit = bb;
    mIrq = 0;
    if (!mBusOff) begin
      if (te) begin
        if (mTx + 8 > 255) begin mBusOff = 1'b1; mTx = 0; mIrq = 1; mRun = 0; end
        else mTx += 8;
      end else if (to && mTx > 0) mTx--;
      if (re) begin if (mRx < 255) mRx++; end
      else if (ro && mRx > 0) mRx--;
    end else if (bv) begin
      if (bb) begin
        mRun++;
        if (mRun == 11) begin
          mRun = 0;
          mTx++;
          if (mTx == 128) begin mBusOff = 1'b0; mTx = 0; mRx = 0; end
        end
      end else mRun = 0;
    end
    pushExp(tag);
    @(negedge canClk);
    txErrEvt = 0; rxErrEvt = 0; txOkEvt = 0; rxOkEvt = 0; bitValid = 0; busBit = 0;
  endtask

  task automatic checkNow(input string tag);
    mIrq = 0;
    pushExp(tag);
    @(negedge canClk);
  endtask

  task automatic recessive(input int n, input string tag);
    for (int i = 0; i < n; i++) applyEvt(0, 0, 0, 0, 1, 1, tag);
  endtask

  task automatic hostWrite(input logic [15:0] d, input logic frz, input string tag);
    @(negedge hostClk);
    freezeMode = frz; hostWrEn = 1'b1; hostWrData = d;
    @(negedge hostClk);
    hostWrEn = 1'b0;
    if (frz) begin
      check(hostBusy === 1'b1, {tag, " busy after write"}, hostBusy, 1);
      for (int i = 0; i < 60 && hostBusy; i++) @(negedge hostClk);
      check(hostBusy === 1'b0, {tag, " busy released"}, hostBusy, 0);
      mTx = d[15:8]; mRx = d[7:0];
    end else begin
      for (int i = 0; i < 12; i++) begin
        @(negedge hostClk);
        check(hostBusy === 1'b0, {tag, " busy stays low"}, hostBusy, 0);
      end
    end
    freezeMode = 1'b0;
    @(negedge canClk);
    checkNow(tag);
  endtask

  initial begin
    #(20 * 100000);
    if (!finished) begin
      nChecks++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge canClk);
    canRstN = 1'b1; hostRstN = 1'b1;
    @(negedge canClk);
    // R1 reset state
    check(hostBusy === 1'b0, "R1 busy", hostBusy, 0);
    checkNow("R1 reset");

    // R3 receive counting
    applyEvt(0, 1, 0, 0, 0, 0, "R3 rx err");
    applyEvt(0, 1, 0, 0, 0, 0, "R3 rx err");
    applyEvt(0, 1, 0, 0, 0, 0, "R3 rx err");
    applyEvt(0, 0, 0, 1, 0, 0, "R3 rx ok");
    // R2 transmit counting
    applyEvt(1, 0, 0, 0, 0, 0, "R2 tx err");
    applyEvt(1, 0, 1, 0, 0, 0, "R2 err beats ok");
    applyEvt(0, 0, 1, 0, 0, 0, "R2 tx ok");
    applyEvt(0, 1, 0, 1, 0, 0, "R3 err beats ok");
    applyEvt(0, 0, 0, 1, 0, 0, "R3 rx ok");
    applyEvt(0, 0, 0, 1, 0, 0, "R3 rx ok");
    applyEvt(0, 0, 0, 1, 0, 0, "R3 rx ok");
    applyEvt(0, 0, 0, 1, 0, 0, "R3 rx ok at zero");

    // R7 write without freeze, R6 write in freeze
    hostWrite(16'h7800, 1'b0, "R7 unfrozen write");
    hostWrite(16'h7800, 1'b1, "R6 load 120/0");
    applyEvt(1, 0, 0, 0, 0, 0, "R4 tx reaches 128");
    hostWrite({8'd128, 8'd130}, 1'b1, "R6 load 128/130");
    applyEvt(0, 0, 1, 0, 0, 0, "R5 tx 127 rx 130 stays passive");
    applyEvt(0, 0, 0, 1, 0, 0, "R5 rx 129");
    applyEvt(0, 0, 0, 1, 0, 0, "R5 rx 128");
    applyEvt(0, 0, 0, 1, 0, 0, "R5 both 127 active");

    // R3 saturation
    hostWrite({8'd0, 8'd255}, 1'b1, "R6 load 0/255");
    applyEvt(0, 1, 0, 0, 0, 0, "R3 saturate");

    // R8 bus-off entry
    hostWrite({8'd250, 8'd5}, 1'b1, "R6 load 250/5");
    applyEvt(1, 0, 0, 0, 0, 0, "R8 overflow to bus-off");
    checkNow("R8 irq one cycle");

    // R9 events ignored in bus-off
    applyEvt(1, 0, 0, 0, 0, 0, "R9 tx err ignored");
    applyEvt(0, 1, 0, 0, 0, 0, "R9 rx err ignored");
    applyEvt(0, 0, 1, 1, 0, 0, "R9 ok ignored");

    // R10 recessive runs
    recessive(11, "R10 first run");
    recessive(5, "R10 partial run");
    applyEvt(0, 0, 0, 0, 1, 0, "R10 dominant restarts");
    recessive(10, "R10 ten after restart");
    recessive(1, "R10 eleventh");

    // R11 recovery
    hostWrite({8'd127, 8'd5}, 1'b1, "R6 load in bus-off");
    recessive(11, "R11 recovery");
    applyEvt(1, 0, 0, 0, 0, 0, "R11 counting resumes");

    repeat (3) @(negedge canClk);
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

endmodule